// File: doc/BRIEF.md
# Digital Silence Detector with Test Noise Source

This block watches a stereo sample stream and raises a single output pin once both channels have carried only zero samples for a long unbroken run of frames. The pin is meant to switch an external mute transistor, so that the analog path stays quiet while the digital input is silent. Samples are counted once per frame, on a one-cycle frame strobe. A sample with any nonzero bit on either channel restarts the run at once.

The same pin can instead carry a pseudo-random bit stream, which serves as a white-noise test signal for speaker and room measurements. A test code input selects the noise. The generator is a maximal-length linear feedback shift register. It advances only on a separate rate tick, which the system provides at 128 times the sample rate. Its sequence repeats every 2^W − 1 bits, which is 2^24 − 1 with the default width. While the noise is on the pin, silence counting carries on unchanged.

Top module: `silence_flag_top`

## Requirements
- R1: After reset the silence run count is zero, the flag is low, and the noise register holds the seed value 1 (only bit 0 set), so the first noise bit on the pin is 0.
- R2: The flag rises in the cycle after the clock edge that takes the 1024th consecutive frame strobe with both channels zero (RUN_FRAMES = 1024). After 1023 such frames it is still low.
- R3: A frame strobe with a nonzero sample on the left channel, the right channel or both clears the run count. The flag is low in the cycle after that edge.
- R4: The run count saturates at its terminal value. The flag stays high for any number of further all-zero frames and never wraps back to low.
- R5: Sample values have no effect on the count or the flag in cycles where the frame strobe is low.
- R6: The noise register is a 24-bit Fibonacci shift register. It shifts left by one bit on each cycle with the noise tick high. The new bit 0 is the XOR of bits 23, 22, 21 and 16, and the pin carries bit 23. Without a tick the register holds its value.
- R7: The noise sequence has a period of exactly 2^W − 1 ticks for the supported register widths (8, 16 and 24 bits).
- R8: When the test code equals 7 the pin carries the noise bit. Every other test code puts the silence flag on the pin.
- R9: Silence counting goes on while the noise is selected. The flag state reached during noise output appears on the pin as soon as the test code leaves 7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| frameStb | input | 1 | One-cycle strobe marking a new stereo frame |
| leftSample | input | SAMPLE_W | Left channel sample, two's complement |
| rightSample | input | SAMPLE_W | Right channel sample, two's complement |
| noiseTick | input | 1 | Noise rate enable, one bit per pulse |
| testCode | input | CODE_W | Test register value; 7 selects noise |
| flagOut | output | 1 | Silence flag or noise bit |

## Verification
The hardest condition to reach from the ports is the noise period. At the default width it is about sixteen million ticks, far more than a practical run, and a broken feedback tap can hide in a sequence that still looks random. The bench therefore checks the first few hundred default-width bits against its own model of the stated polynomial. It also checks the full period on a second, 8-bit instance: the bits repeat after 255 ticks, do not repeat after 85 or 51 ticks, and hold exactly 128 ones per period. The silent state itself is reached with long back-to-back strobe runs, and single nonzero samples are placed just before and just after the terminal count.

// File: rtl/silence_pkg.sv
package silence_pkg;

  // Strobes from control to datapath, valid for one cycle
  typedef struct packed {
    logic zeroFrame;  // frame strobe with both channels zero
    logic liveFrame;  // frame strobe with any nonzero sample
    logic noiseStep;  // advance the noise register
    logic noiseSel;   // put the noise bit on the pin
  } ctlStrobes_t;

  // Feedback masks of maximal-length Fibonacci registers (bit i = tap i)
  function automatic logic [31:0] tapMask(input int width);
    case (width)
      8:       return 32'h0000_00B8;  // taps 8,6,5,4
      16:      return 32'h0000_D008;  // taps 16,15,13,4
      24:      return 32'h00E1_0000;  // taps 24,23,22,17
      default: return 32'h0000_0000;
    endcase
  endfunction

endpackage

// File: rtl/silence_ctrl.sv
module silence_ctrl
  import silence_pkg::*;
#(
  parameter int SAMPLE_W   = 24,
  parameter int CODE_W     = 4,
  parameter int NOISE_CODE = 7
) (
  input  logic                frameStb,
  input  logic [SAMPLE_W-1:0] leftSample,
  input  logic [SAMPLE_W-1:0] rightSample,
  input  logic                noiseTick,
  input  logic [CODE_W-1:0]   testCode,
  output ctlStrobes_t         strobes
);

  localparam logic [CODE_W-1:0] SEL_CODE = CODE_W'(NOISE_CODE);

  logic bothZero;

  always_comb begin
    bothZero          = (leftSample == '0) && (rightSample == '0);
    strobes.zeroFrame = frameStb && bothZero;
    strobes.liveFrame = frameStb && !bothZero;
    strobes.noiseStep = noiseTick;
    strobes.noiseSel  = (testCode == SEL_CODE);
  end

endmodule

// File: rtl/silence_dpath.sv
module silence_dpath
  import silence_pkg::*;
#(
  parameter int RUN_FRAMES = 1024,
  parameter int NOISE_W    = 24
) (
  input  logic        clk,
  input  logic        rstN,
  input  ctlStrobes_t strobes,
  output logic        flagOut
);

  localparam int                 CNT_W    = $clog2(RUN_FRAMES + 1);
  localparam logic [CNT_W-1:0]   TERM     = CNT_W'(RUN_FRAMES);
  localparam logic [31:0]        TAP_FULL = tapMask(NOISE_W);
  localparam logic [NOISE_W-1:0] TAPS     = TAP_FULL[NOISE_W-1:0];
  localparam logic [NOISE_W-1:0] SEED     = NOISE_W'(1);

  logic [CNT_W-1:0]   runCnt;
  logic [NOISE_W-1:0] noiseReg;
  logic               silent;
  logic               noiseBit;

  // Silence run counter, saturating at the terminal count
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                  runCnt <= '0;
    else if (strobes.liveFrame)                 runCnt <= '0;
    else if (strobes.zeroFrame && runCnt != TERM) runCnt <= runCnt + 1'b1;
  end

  assign silent = (runCnt == TERM);

  // Fibonacci noise register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  noiseReg <= SEED;
    else if (strobes.noiseStep) noiseReg <= {noiseReg[NOISE_W-2:0], ^(noiseReg & TAPS)};
  end

  assign noiseBit = noiseReg[NOISE_W-1];
  assign flagOut  = strobes.noiseSel ? noiseBit : silent;

  // R3: a live frame clears the run and drops the flag
  p_clear_on_live_r3: assert property (@(posedge clk) disable iff (!rstN)
    strobes.liveFrame |=> (runCnt == '0) && !silent);

  // R4: once silent, only a live frame leaves that state
  p_hold_silent_r4: assert property (@(posedge clk) disable iff (!rstN)
    (silent && !strobes.liveFrame) |=> silent);

  // R4: the count never passes its terminal value
  p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rstN)
    runCnt <= TERM);

  // R2: the flag rises only on a zero frame
  p_rise_on_zero_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(silent) |-> $past(strobes.zeroFrame));

  // R5: with no frame strobe the count does not move
  p_idle_stable_r5: assert property (@(posedge clk) disable iff (!rstN)
    !(strobes.zeroFrame || strobes.liveFrame) |=> $stable(runCnt));

  // R6: the noise register holds without a tick and never locks up at zero
  p_noise_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.noiseStep |=> $stable(noiseReg));

  p_noise_alive_r7: assert property (@(posedge clk) disable iff (!rstN)
    noiseReg != '0);

endmodule

// File: rtl/silence_flag_top.sv
module silence_flag_top
  import silence_pkg::*;
#(
  parameter int SAMPLE_W   = 24,
  parameter int CODE_W     = 4,
  parameter int NOISE_CODE = 7,
  parameter int RUN_FRAMES = 1024,
  parameter int NOISE_W    = 24
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                frameStb,
  input  logic [SAMPLE_W-1:0] leftSample,
  input  logic [SAMPLE_W-1:0] rightSample,
  input  logic                noiseTick,
  input  logic [CODE_W-1:0]   testCode,
  output logic                flagOut
);

  ctlStrobes_t strobes;

  silence_ctrl #(
    .SAMPLE_W  (SAMPLE_W),
    .CODE_W    (CODE_W),
    .NOISE_CODE(NOISE_CODE)
  ) i_ctrl (
    .frameStb   (frameStb),
    .leftSample (leftSample),
    .rightSample(rightSample),
    .noiseTick  (noiseTick),
    .testCode   (testCode),
    .strobes    (strobes)
  );

  silence_dpath #(
    .RUN_FRAMES(RUN_FRAMES),
    .NOISE_W   (NOISE_W)
  ) i_dpath (
    .clk    (clk),
    .rstN   (rstN),
    .strobes(strobes),
    .flagOut(flagOut)
  );

endmodule

// File: tb/test_silence_flag_top.sv
module test_silence_flag_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        frameStb = 1'b0;
  logic [23:0] leftSample = '0;
  logic [23:0] rightSample = '0;
  logic        noiseTick = 1'b0;
  logic [3:0]  testCode = '0;
  logic        flagOut;
  logic        noiseTick8 = 1'b0;
  logic        flagOut8;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #2 clk = ~clk;  // 250 MHz

  silence_flag_top i_silence_flag_top (
    .clk(clk), .rstN(rstN), .frameStb(frameStb), .leftSample(leftSample),
    .rightSample(rightSample), .noiseTick(noiseTick), .testCode(testCode),
    .flagOut(flagOut)
  );

  // Narrow noise register so that a full period fits in the run (R7)
  silence_flag_top #(.NOISE_W(8)) i_silence_flag_top8 (
    .clk(clk), .rstN(rstN), .frameStb(1'b0), .leftSample(24'd0),
    .rightSample(24'd0), .noiseTick(noiseTick8), .testCode(4'd7),
    .flagOut(flagOut8)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 200000) begin
      errors++;
      $display("FAIL watchdog act=%0d exp=%0d", cycles, 200000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  typedef struct packed {
    logic [15:0] n;
    logic [23:0] l;
    logic [23:0] r;
    logic        e;
  } vec_t;

  // Frames to apply, sample pair, expected flag afterwards (state carries over)
  localparam vec_t VEC [10] = '{
    '{16'd1,    24'h000005, 24'h000000, 1'b0},  // R3 left live
    '{16'd1023, 24'h000000, 24'h000000, 1'b0},  // R2 one short
    '{16'd1,    24'h000000, 24'h000000, 1'b1},  // R2 terminal
    '{16'd500,  24'h000000, 24'h000000, 1'b1},  // R4 saturate
    '{16'd1,    24'h000000, 24'hFFFFFF, 1'b0},  // R3 right live
    '{16'd1024, 24'h000000, 24'h000000, 1'b1},  // R2 again
    '{16'd1,    24'h800000, 24'h000001, 1'b0},  // R3 both live
    '{16'd1000, 24'h000000, 24'h000000, 1'b0},  // R2 partial
    '{16'd23,   24'h000000, 24'h000000, 1'b0},  // R2 1023 total
    '{16'd1,    24'h000000, 24'h000000, 1'b1}   // R2 terminal
  };

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic frames(input int n, input logic [23:0] l, input logic [23:0] r);
    leftSample  = l;
    rightSample = r;
    frameStb    = 1'b1;
    for (int i = 0; i < n; i++) @(posedge clk) #1;
    frameStb    = 1'b0;
    leftSample  = '0;
    rightSample = '0;
  endtask

  task automatic doReset();
    rstN = 1'b0;
    @(posedge clk) #1;
    @(posedge clk) #1;
    rstN = 1'b1;
    @(posedge clk) #1;
  endtask

  logic [23:0] model;
  logic        bits8 [510];
  int          ones;
  logic        diff85, diff51, same255;

  initial begin
    doReset();
    chk("R1 flag low after reset", flagOut, 1'b0);
    testCode = 4'd7; #1;
    chk("R1 seed bit", flagOut, 1'b0);
    testCode = 4'd0; #1;

    // R5: sample values without a strobe do nothing
    leftSample = 24'h123456;
    rightSample = 24'h000000;
    repeat (20) @(posedge clk) #1;
    leftSample = '0;
    repeat (1100) @(posedge clk) #1;
    chk("R5 zero samples without strobe", flagOut, 1'b0);

    foreach (VEC[k]) begin
      frames(int'(VEC[k].n), VEC[k].l, VEC[k].r);
      chk($sformatf("R2/R3/R4 vector %0d", k), flagOut, VEC[k].e);
    end

    // R5: live samples without a strobe leave the flag high
    leftSample = 24'h000001;
    rightSample = 24'h7FFFFF;
    repeat (10) @(posedge clk) #1;
    chk("R5 live samples without strobe", flagOut, 1'b1);
    leftSample = '0;
    rightSample = '0;

    // R8: every code but 7 shows the flag; 7 shows the noise bit (0 at seed)
    doReset();
    frames(1024, 24'd0, 24'd0);
    for (int c = 0; c < 16; c++) begin
      testCode = 4'(c); #1;
      chk($sformatf("R8 code %0d", c), flagOut, (c == 7) ? 1'b0 : 1'b1);
    end

    // R9: counting continues while noise is selected
    doReset();
    testCode = 4'd7;
    frames(1024, 24'd0, 24'd0);
    testCode = 4'd0; #1;
    chk("R9 flag reached under noise", flagOut, 1'b1);
    testCode = 4'd7;
    frames(1, 24'd0, 24'd9);
    testCode = 4'd3; #1;
    chk("R9 clear under noise", flagOut, 1'b0);

    // R6: noise sequence against the stated polynomial, seed 1, output bit 23
    doReset();
    testCode = 4'd7; #1;
    model = 24'h000001;
    for (int i = 0; i < 400; i++) begin
      chk($sformatf("R6 noise bit %0d", i), flagOut, model[23]);
      noiseTick = 1'b1;
      @(posedge clk) #1;
      noiseTick = 1'b0;
      model = {model[22:0], model[23] ^ model[22] ^ model[21] ^ model[16]};
      if (i % 50 == 0) begin
        @(posedge clk) #1;
        chk("R6 hold without tick", flagOut, model[23]);
      end
    end

    // R7: full period on the 8-bit instance
    doReset();
    for (int i = 0; i < 510; i++) begin
      bits8[i] = flagOut8;
      noiseTick8 = 1'b1;
      @(posedge clk) #1;
      noiseTick8 = 1'b0;
    end
    ones = 0;
    same255 = 1'b1;
    diff85 = 1'b0;
    diff51 = 1'b0;
    for (int i = 0; i < 255; i++) begin
      if (bits8[i]) ones++;
      if (bits8[i] !== bits8[i+255]) same255 = 1'b0;
      if (bits8[i] !== bits8[i+85]) diff85 = 1'b1;
      if (bits8[i] !== bits8[i+51]) diff51 = 1'b1;
    end
    chk("R7 repeats after 255", same255, 1'b1);
    chk("R7 no period 85", diff85, 1'b1);
    chk("R7 no period 51", diff51, 1'b1);
    checks++;
    if (ones != 128) begin
      errors++;
      $display("FAIL R7 ones per period act=%0d exp=%0d", ones, 128);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule